// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter that is read over a three-wire serial link. A host pulls the active-low chip select low to freeze the sample and start a conversion. It then toggles a serial clock. Each rising edge of that clock advances the conversion and moves the next bit onto the data line. The block drives a trial code to an external capacitive DAC and reads back a single comparator decision. The result is streamed out while the conversion is still running, so no separate conversion wait is needed.

The stream carries a preamble of three zeros, then the 12 result bits with the most significant bit first. Any further clock edges produce zeros. Releasing chip select early abandons the conversion and returns the sampler to tracking. An active-low shutdown input holds the block idle. All inputs are sampled on the block's own clock, `clk_i`. Serial clock and chip select edges are found by comparing each input with its value at the previous clock edge.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `hold_o`, `dout_en_o` and `dout_o` are 0 and `dac_code_o` is 0.
- R2: A falling edge of `cs_ni` seen while `shdn_ni` is 1 sets `hold_o` and `dout_en_o` to 1 on the next clock. It also drives `dout_o` to 0 and loads `dac_code_o` with only bit 11 set (0x800).
- R3: While a conversion is active, `dout_o` changes only on the clock after a rising edge of `sclk_i` has been seen.
- R4: The first and second rising edges of `sclk_i` after the start both leave `dout_o` at 0. Together with the 0 driven at the start, this makes three leading zeros.
- R5: Rising edges 3 to 14 put result bits 11 down to 0 on `dout_o`, one bit per edge. The result is unipolar straight binary: an input at or above full scale gives 4095 and an input of zero gives 0.
- R6: On each decision edge, the trial bit currently set in `dac_code_o` is kept if `comp_i` is 1 and cleared if it is 0. The next lower bit is then set as the new trial. After edge 14, `dac_code_o` equals the result.
- R7: Rising edges after the 14th, while `cs_ni` stays low, drive `dout_o` to 0 and leave `dac_code_o` unchanged.
- R8: `cs_ni` high returns the block to idle on the next clock, whether the conversion has finished or not. A later falling edge restarts from the first leading zero.
- R9: `shdn_ni` low forces the block idle on the next clock. A chip-select falling edge while `shdn_ni` is low starts nothing, and raising `shdn_ni` while `cs_ni` stays low does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; falling edge starts a conversion |
| sclk_i | input | 1 | Serial clock from the host |
| shdn_ni | input | 1 | Shutdown, active low |
| comp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| dac_code_o | output | 12 | Trial code for the capacitive DAC |
| hold_o | output | 1 | 1 = hold, 0 = track |
| dout_o | output | 1 | Serial data value |
| dout_en_o | output | 1 | Serial data drive enable (0 = high impedance) |

## Verification
The assertions assume that `cs_ni`, `sclk_i` and `shdn_ni` are already synchronous to `clk_i`. They also assume that each serial clock level lasts at least one `clk_i` cycle, and that `sclk_i` is low while reset is asserted, so that the edge history the checker builds from its own samples matches the block's. The bench meets these assumptions by changing every input on the falling edge of `clk_i` and holding each serial clock phase for a full cycle. The comparator is modelled as an unsigned compare of a bench-held input value against `dac_code_o`, so `comp_i` always reflects the trial code on the current clock.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int LEAD  = 3,
  localparam int IDX_W = $clog2(WIDTH),
  localparam int LAST  = LEAD + WIDTH - 1,
  localparam int CNT_W = $clog2(LAST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             cs_fall_i,
  input  logic             shdn_ni,
  input  logic             sclk_rise_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             clear_o,
  output logic             step_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  localparam int TOPI = WIDTH + LEAD - 2;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   diff;

  assign clear_o = cs_ni | ~shdn_ni;
  assign start_o = cs_fall_i & shdn_ni;
  // edge number cnt_q+1 carries a result bit once it reaches LEAD
  assign step_o  = (state_q == ST_CONV) & sclk_rise_i &
                   ({1'b0, cnt_q} >= (CNT_W+1)'(LEAD - 1));
  assign diff      = (CNT_W+1)'(TOPI) - {1'b0, cnt_q};
  assign bit_idx_o = IDX_W'(diff);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (clear_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_o) begin
      state_q <= ST_CONV;
      cnt_q   <= '0;
    end else if ((state_q == ST_CONV) && sclk_rise_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(LAST - 1)) state_q <= ST_DONE;
    end
  end
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int WIDTH = 12,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             comp_i,
  output logic [WIDTH-1:0] code_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;
    logic arm_next;

    if (i < WIDTH - 1) begin : g_arm
      assign arm_next = step_i & (bit_idx_i == IDX_W'(i + 1));
    end else begin : g_top
      assign arm_next = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  bit_q <= 1'b0;
      else if (clear_i)                             bit_q <= 1'b0;
      else if (start_i)                             bit_q <= (i == WIDTH - 1);
      else if (step_i && bit_idx_i == IDX_W'(i))    bit_q <= comp_i;
      else if (arm_next)                            bit_q <= 1'b1;
    end

    assign code_o[i] = bit_q;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int WIDTH = 12,
  parameter int LEAD  = 3,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             shdn_ni,
  input  logic             comp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             hold_o,
  output logic             dout_o,
  output logic             dout_en_o
);
  logic sclk_rise, sclk_fall_unused;
  logic cs_rise_unused, cs_fall;
  logic busy, start, clear, step;
  logic [IDX_W-1:0] bit_idx;
  logic dout_q;

  sar_edge_det #(.RST_VAL(1'b0)) u_sclk_det (
    .clk_i, .rst_ni, .sig_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall_unused)
  );

  sar_edge_det #(.RST_VAL(1'b1)) u_cs_det (
    .clk_i, .rst_ni, .sig_i(cs_ni), .rise_o(cs_rise_unused), .fall_o(cs_fall)
  );

  sar_seq_ctrl #(.WIDTH(WIDTH), .LEAD(LEAD)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .cs_fall_i(cs_fall), .shdn_ni,
    .sclk_rise_i(sclk_rise), .busy_o(busy), .start_o(start),
    .clear_o(clear), .step_o(step), .bit_idx_o(bit_idx)
  );

  sar_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk_i, .rst_ni, .clear_i(clear), .start_i(start), .step_i(step),
    .bit_idx_i(bit_idx), .comp_i, .code_o(dac_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dout_q <= 1'b0;
    else if (clear || start)    dout_q <= 1'b0;
    else if (busy && sclk_rise) dout_q <= step ? comp_i : 1'b0;
  end

  assign dout_o    = dout_q;
  assign hold_o    = busy;
  assign dout_en_o = busy;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             sclk_i,
  input logic             shdn_ni,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             hold_o,
  input logic             dout_o,
  input logic             dout_en_o
);
  localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |-> (!dout_o && dac_code_o == '0));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_ni) && shdn_ni) |=>
      (hold_o && dout_en_o && !dout_o && dac_code_o == FIRST_TRIAL));

  p_dout_on_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && shdn_ni && !(sclk_i && !$past(sclk_i))) |=> $stable(dout_o));

  p_cs_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!hold_o && !dout_en_o));

  p_shutdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |=> (!hold_o && !dout_en_o));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
  .shdn_ni(shdn_ni), .dac_code_o(dac_code_o), .hold_o(hold_o),
  .dout_o(dout_o), .dout_en_o(dout_en_o)
);

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int NVEC = 8;
  localparam logic [W-1:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                          12'hA5A, 12'h123, 12'h001, 12'hC3C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, shdn_n = 1'b1;
  logic [W-1:0] vin = '0;
  logic [W-1:0] code;
  logic comp, hold, dout, dout_en;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign comp = (vin >= code);

  sar_conv_seq u_sar_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .shdn_ni(shdn_n),
    .comp_i(comp), .dac_code_o(code), .hold_o(hold), .dout_o(dout), .dout_en_o(dout_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sclk_edge;
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk) cs_n = v;
    @(negedge clk);
  endtask

  // full read; checks the 15-bit stream and final trial code
  task automatic run_conv(input logic [W-1:0] v, input string req);
    logic [14:0] got;
    vin = v;
    set_cs(1'b0);
    check({req, " R2 enable"}, {hold, dout_en}, 2'b11);
    got[14] = dout;
    for (int e = 1; e <= 14; e++) begin
      sclk_edge();
      got[14 - e] = dout;
    end
    check({req, " R4 R5 stream"}, 32'(got), 32'({3'b000, v}));
    check({req, " R6 final code"}, 32'(code), 32'(v));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {hold, dout_en, dout, code}, '0);

    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC[i], "vec");
      set_cs(1'b1);
      check("R8 idle after read", {hold, dout_en, code}, '0);
    end

    // R2 start values and R6 trial progression, R3 stability
    vin = 12'hA5A;
    set_cs(1'b0);
    check("R2 first trial", 32'(code), 32'h800);
    check("R2 dout low", 32'(dout), 0);
    sclk_edge(); sclk_edge();
    check("R4 lead zero", 32'(dout), 0);
    check("R6 no decision before edge 3", 32'(code), 32'h800);
    sclk_edge();
    check("R6 keep bit11 set bit10", 32'(code), 32'hC00);
    check("R5 msb", 32'(dout), 1);
    repeat (4) @(negedge clk);
    check("R3 dout holds without sclk", 32'(dout), 1);
    sclk_edge();
    check("R6 clear bit10 set bit9", 32'(code), 32'hA00);
    check("R3 dout follows edge", 32'(dout), 0);
    set_cs(1'b1);

    // R7 trailing zeros
    run_conv(12'hFFF, "R7 pre");
    check("R7 lsb is one", 32'(dout), 1);
    sclk_edge();
    check("R7 trailing zero", 32'(dout), 0);
    check("R7 code unchanged", 32'(code), 32'hFFF);
    sclk_edge(); sclk_edge();
    check("R7 trailing zeros continue", {dout, code}, {1'b0, 12'hFFF});
    set_cs(1'b1);

    // R8 abort mid conversion then restart
    vin = 12'h5A5;
    set_cs(1'b0);
    repeat (6) sclk_edge();
    set_cs(1'b1);
    check("R8 abort idle", {hold, dout_en, dout, code}, '0);
    run_conv(12'h3C3, "R8 restart");
    set_cs(1'b1);

    // R9 shutdown
    vin = 12'h777;
    set_cs(1'b0);
    repeat (4) sclk_edge();
    @(negedge clk) shdn_n = 1'b0;
    @(negedge clk);
    check("R9 shutdown forces idle", {hold, dout_en, code}, '0);
    set_cs(1'b1);
    set_cs(1'b0);
    check("R9 no start in shutdown", {hold, dout_en}, 2'b00);
    @(negedge clk) shdn_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 no start on wake with cs low", {hold, dout_en}, 2'b00);
    sclk_edge();
    check("R9 sclk ignored while idle", {dout, code}, '0);
    set_cs(1'b1);
    run_conv(12'h777, "R9 after wake");
    set_cs(1'b1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule